// File: doc/BRIEF.md
# Phase-Split Video RAM Arbiter

This block shares one byte-wide RAM between a CPU with a 24-bit address space and a display fetch path by splitting every CPU clock period into two halves. While the CPU clock is low, the CPU places its bank byte (address bits 23..16) on its data bus. The block captures that byte, and the RAM belongs to the video side. A video address counter supplies the RAM address, and the byte read back goes into a shift register that produces the serial pixel stream. While the CPU clock is high, the RAM sees the CPU address, made of the held bank byte and the CPU's sixteen address lines, and the CPU data path is open for reads and writes.

The RAM holds 512 KiB, so only the lowest 19 address bits reach it and the upper bank bits are dropped. The CPU data bus and the RAM data bus are kept apart for the whole low half. This stops the bank byte from reaching the RAM and stops video fetch data from reaching the CPU. The video side may also write into the RAM during the low half, but only while blanking is active. Everything runs on one system clock, and the CPU clock level comes in as a sampled input.

Top module: `vram_phase_arbiter`

## Requirements
- R1: While `phi_hi` is 0, `ram_addr` equals the video address counter. While `phi_hi` is 1, `ram_addr` is {held bank bits 2..0, `cpu_addr`}, and bank bits 7..3 never reach the RAM.
- R2: On every clock edge with `phi_hi` = 0, the held bank byte takes the value of `cpu_dout`. On edges with `phi_hi` = 1 it keeps its value, so changes on `cpu_dout` during the high half leave `ram_addr` unchanged.
- R3: `cpu_din` equals `ram_rdata` while `phi_hi` is 1 and is 8'h00 while `phi_hi` is 0.
- R4: While `phi_hi` is 1, `ram_we` equals `cpu_we`. While `phi_hi` is 0, `ram_we` is 1 only when `vid_wr_req` and `vid_blank` are both 1. `ram_oe` is always the inverse of `ram_we`.
- R5: `ram_wdata` equals `cpu_dout` while `phi_hi` is 1 and equals `vid_wr_data` while `phi_hi` is 0.
- R6: On the clock edge where `phi_hi` is 1 and was 0 at the previous edge, the video address counter increases by one, wrapping from 19'h7FFFF to 0.
- R7: A clock edge with `vid_frame_start` = 1 loads the counter with `vid_frame_base`, and this takes priority over the increment.
- R8: The block stores the byte read at each low-half edge without a video write. At the edge that starts a high half, this byte loads the shift register, unless a video write took place during that low half.
- R9: `pix_out` is bit 7 of the shift register. An edge with `pix_tick` = 1 and no load shifts the register left by one, with a 0 entering bit 0. A load takes priority over a shift.
- R10: While `rst` is 1, the counter, the held bank byte, the fetch byte and the shift register are cleared, so `pix_out` is 0 and a low-half `ram_addr` is 0 right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phi_hi | input | 1 | Sampled CPU clock level, 1 = CPU half |
| cpu_addr | input | 16 | CPU address lines 15..0 |
| cpu_dout | input | 8 | CPU data bus: bank byte in the low half, write data in the high half |
| cpu_we | input | 1 | CPU write strobe |
| cpu_din | output | 8 | Read data returned to the CPU |
| ram_addr | output | 19 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| ram_we | output | 1 | RAM write enable |
| ram_oe | output | 1 | RAM output enable |
| vid_frame_start | input | 1 | Frame-start pulse that reloads the video counter |
| vid_frame_base | input | 19 | Frame start address |
| vid_blank | input | 1 | Horizontal or vertical blanking active |
| vid_wr_req | input | 1 | Video-side write request |
| vid_wr_data | input | 8 | Video-side write data |
| pix_tick | input | 1 | Pixel clock enable |
| pix_out | output | 1 | Serial pixel stream |

## Verification
The checker assumes that `phi_hi` is a clean level that holds for at least one system clock per half. The step check also assumes that `vid_frame_start` is a single-edge event that the counter check can exclude. The stimulus changes all inputs shortly after each rising edge. It holds each CPU half for two to four clocks with randomly chosen lengths, and it keeps toggling the phase through reset, so the first post-reset edge matches the previous-edge history. Blanking, video write requests, frame starts and pixel ticks are drawn at different rates, so that low halves with and without video writes, loads that coincide with ticks, and reloads on a phase edge all occur. The frame base is set to the top of the address range from time to time to drive the counter through its wrap.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    localparam int CPU_AW  = 16;
    localparam int BANK_W  = 8;
    localparam int RAM_AW  = 19;
    localparam int DATA_W  = 8;

    typedef struct packed {
        logic [RAM_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
        logic              oe;
    } ram_req_t;

    typedef enum logic {
        HALF_VIDEO = 1'b0,
        HALF_CPU   = 1'b1
    } half_e;

    function automatic half_e half_of(input logic phi);
        return phi ? HALF_CPU : HALF_VIDEO;
    endfunction

endpackage

// File: rtl/vram_bank_mux.sv
module vram_bank_mux
    import vram_arb_pkg::*;
#(
    parameter int CA_W = CPU_AW,
    parameter int BK_W = BANK_W,
    parameter int RA_W = RAM_AW,
    parameter int D_W  = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            phi_hi,
    input  logic [CA_W-1:0] cpu_addr,
    input  logic [D_W-1:0]  cpu_dout,
    input  logic            cpu_we,
    input  logic [RA_W-1:0] vaddr,
    input  logic            vid_blank,
    input  logic            vid_wr_req,
    input  logic [D_W-1:0]  vid_wr_data,
    input  logic [D_W-1:0]  ram_rdata,
    output logic [BK_W-1:0] bank_q,
    output logic            vid_we,
    output ram_req_t        req,
    output logic [D_W-1:0]  cpu_din
);
    localparam int KEEP_W = RA_W - CA_W;

    half_e             half;
    logic [RA_W-1:0]   cpu_full;

    assign half = half_of(phi_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (half == HALF_VIDEO) begin
            bank_q <= cpu_dout[BK_W-1:0];
        end
    end

    generate
        if (KEEP_W > 0) begin : g_banked
            assign cpu_full = {bank_q[KEEP_W-1:0], cpu_addr};
        end else begin : g_flat
            assign cpu_full = cpu_addr[RA_W-1:0];
        end
    endgenerate

    assign vid_we = (half == HALF_VIDEO) && vid_wr_req && vid_blank;

    always_comb begin
        if (half == HALF_CPU) begin
            req.addr  = cpu_full;
            req.wdata = cpu_dout;
            req.we    = cpu_we;
            cpu_din   = ram_rdata;
        end else begin
            req.addr  = vaddr;
            req.wdata = vid_wr_data;
            req.we    = vid_we;
            cpu_din   = '0;
        end
        req.oe = !req.we;
    end

endmodule

// File: rtl/vram_video_fetch.sv
module vram_video_fetch
    import vram_arb_pkg::*;
#(
    parameter int RA_W = RAM_AW,
    parameter int D_W  = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            phi_hi,
    input  logic            vid_we,
    input  logic            frame_start,
    input  logic [RA_W-1:0] frame_base,
    input  logic [D_W-1:0]  ram_rdata,
    output logic [RA_W-1:0] vaddr,
    output logic            load,
    output logic [D_W-1:0]  load_byte
);
    logic phi_prev;
    logic wr_seen;
    logic rise;

    always_ff @(posedge clk) begin
        phi_prev <= phi_hi;
    end

    assign rise      = phi_hi && !phi_prev;
    assign load      = rise && !wr_seen && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr     <= '0;
            load_byte <= '0;
            wr_seen   <= 1'b0;
        end else begin
            if (frame_start) begin
                vaddr <= frame_base;
            end else if (rise) begin
                vaddr <= vaddr + 1'b1;
            end
            if (!phi_hi) begin
                if (!vid_we) begin
                    load_byte <= ram_rdata;
                end
                wr_seen <= wr_seen || vid_we;
            end else if (rise) begin
                wr_seen <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vram_pixel_shifter.sv
module vram_pixel_shifter
    import vram_arb_pkg::*;
#(
    parameter int D_W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [D_W-1:0] load_byte,
    input  logic           pix_tick,
    output logic [D_W-1:0] shreg,
    output logic           pix_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= load_byte;
        end else if (pix_tick) begin
            shreg <= {shreg[D_W-2:0], 1'b0};
        end
    end

    assign pix_out = shreg[D_W-1];

endmodule

// File: rtl/vram_phase_arbiter.sv
module vram_phase_arbiter
    import vram_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                phi_hi,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_dout,
    input  logic                cpu_we,
    output logic [DATA_W-1:0]   cpu_din,
    output logic [RAM_AW-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                ram_we,
    output logic                ram_oe,
    input  logic                vid_frame_start,
    input  logic [RAM_AW-1:0]   vid_frame_base,
    input  logic                vid_blank,
    input  logic                vid_wr_req,
    input  logic [DATA_W-1:0]   vid_wr_data,
    input  logic                pix_tick,
    output logic                pix_out
);
    logic [BANK_W-1:0] bank_q;
    logic [RAM_AW-1:0] vaddr;
    logic              vid_we;
    logic              sh_load;
    logic [DATA_W-1:0] sh_byte;
    logic [DATA_W-1:0] sh_q;
    ram_req_t          req;

    vram_bank_mux u_mux (
        .clk         (clk),
        .rst         (rst),
        .phi_hi      (phi_hi),
        .cpu_addr    (cpu_addr),
        .cpu_dout    (cpu_dout),
        .cpu_we      (cpu_we),
        .vaddr       (vaddr),
        .vid_blank   (vid_blank),
        .vid_wr_req  (vid_wr_req),
        .vid_wr_data (vid_wr_data),
        .ram_rdata   (ram_rdata),
        .bank_q      (bank_q),
        .vid_we      (vid_we),
        .req         (req),
        .cpu_din     (cpu_din)
    );

    vram_video_fetch u_fetch (
        .clk         (clk),
        .rst         (rst),
        .phi_hi      (phi_hi),
        .vid_we      (vid_we),
        .frame_start (vid_frame_start),
        .frame_base  (vid_frame_base),
        .ram_rdata   (ram_rdata),
        .vaddr       (vaddr),
        .load        (sh_load),
        .load_byte   (sh_byte)
    );

    vram_pixel_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_byte (sh_byte),
        .pix_tick  (pix_tick),
        .shreg     (sh_q),
        .pix_out   (pix_out)
    );

    assign ram_addr  = req.addr;
    assign ram_wdata = req.wdata;
    assign ram_we    = req.we;
    assign ram_oe    = req.oe;

endmodule

// File: rtl/vram_phase_arbiter_chk.sv
module vram_phase_arbiter_chk
    import vram_arb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              phi_hi,
    input logic [DATA_W-1:0] cpu_din,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              ram_we,
    input logic              ram_oe,
    input logic              vid_blank,
    input logic              vid_frame_start,
    input logic [RAM_AW-1:0] vid_frame_base,
    input logic              pix_tick,
    input logic [BANK_W-1:0] bank_q,
    input logic [RAM_AW-1:0] vaddr,
    input logic              sh_load,
    input logic [DATA_W-1:0] sh_q
);
    p_addr_video_r1: assert property (@(posedge clk) disable iff (rst)
        !phi_hi |-> ram_addr == vaddr);

    p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (phi_hi && $past(phi_hi)) |-> $stable(bank_q));

    p_din_isolated_r3: assert property (@(posedge clk) disable iff (rst)
        !phi_hi |-> cpu_din == '0);

    p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        ram_we != ram_oe);

    p_vid_we_blank_r4: assert property (@(posedge clk) disable iff (rst)
        (!phi_hi && ram_we) |-> vid_blank);

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (phi_hi && !$past(phi_hi) && !vid_frame_start)
            |=> vaddr == RAM_AW'($past(vaddr) + 1'b1));

    p_frame_load_r7: assert property (@(posedge clk) disable iff (rst)
        vid_frame_start |=> vaddr == $past(vid_frame_base));

    p_shift_r9: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && !sh_load) |=> sh_q == {$past(sh_q[DATA_W-2:0]), 1'b0});

endmodule

bind vram_phase_arbiter vram_phase_arbiter_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .phi_hi          (phi_hi),
    .cpu_din         (cpu_din),
    .ram_addr        (ram_addr),
    .ram_we          (ram_we),
    .ram_oe          (ram_oe),
    .vid_blank       (vid_blank),
    .vid_frame_start (vid_frame_start),
    .vid_frame_base  (vid_frame_base),
    .pix_tick        (pix_tick),
    .bank_q          (bank_q),
    .vaddr           (vaddr),
    .sh_load         (sh_load),
    .sh_q            (sh_q)
);

// File: tb/vram_phase_arbiter_test.sv
module vram_phase_arbiter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi_hi = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_dout = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_din;
    logic [18:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata;
    logic        ram_we;
    logic        ram_oe;
    logic        vid_frame_start = 1'b0;
    logic [18:0] vid_frame_base = '0;
    logic        vid_blank = 1'b0;
    logic        vid_wr_req = 1'b0;
    logic [7:0]  vid_wr_data = '0;
    logic        pix_tick = 1'b0;
    logic        pix_out;

    int total = 0;
    int bad   = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vram_phase_arbiter uut (
        .clk(clk), .rst(rst), .phi_hi(phi_hi),
        .cpu_addr(cpu_addr), .cpu_dout(cpu_dout), .cpu_we(cpu_we),
        .cpu_din(cpu_din), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_oe(ram_oe),
        .vid_frame_start(vid_frame_start), .vid_frame_base(vid_frame_base),
        .vid_blank(vid_blank), .vid_wr_req(vid_wr_req),
        .vid_wr_data(vid_wr_data), .pix_tick(pix_tick), .pix_out(pix_out)
    );

    // Environment RAM: 512 aliased bytes
    logic [7:0] mem [0:511];
    assign ram_rdata = mem[ram_addr[8:0]];
    always @(posedge clk) if (ram_we) mem[ram_addr[8:0]] <= ram_wdata;

    // Behavioural reference state
    logic [7:0]  m_bank, m_fbuf, m_sh;
    logic [18:0] m_cnt;
    logic        m_wseen, m_prev;

    function automatic logic [18:0] exp_addr();
        return phi_hi ? {m_bank[2:0], cpu_addr} : m_cnt;
    endfunction

    function automatic logic exp_we();
        return phi_hi ? cpu_we : (vid_wr_req && vid_blank);
    endfunction

    always @(posedge clk) begin
        m_prev <= phi_hi;
        if (rst) begin
            m_bank <= 0; m_fbuf <= 0; m_sh <= 0; m_cnt <= 0; m_wseen <= 0;
        end else begin
            if (!phi_hi) begin
                m_bank <= cpu_dout;
                if (!(vid_wr_req && vid_blank)) m_fbuf <= mem[m_cnt[8:0]];
                m_wseen <= m_wseen || (vid_wr_req && vid_blank);
            end else if (!m_prev) begin
                m_wseen <= 0;
            end
            if (vid_frame_start) m_cnt <= vid_frame_base;
            else if (phi_hi && !m_prev) m_cnt <= m_cnt + 19'd1;
            if (phi_hi && !m_prev && !m_wseen) m_sh <= m_fbuf;
            else if (pix_tick) m_sh <= {m_sh[6:0], 1'b0};
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            if (phi_hi) begin
                check("R2", "cpu-half ram_addr", ram_addr, exp_addr());
                check("R3", "cpu_din high", cpu_din, mem[exp_addr()[8:0]]);
                check("R5", "ram_wdata high", ram_wdata, cpu_dout);
            end else begin
                check("R1", "video-half ram_addr", ram_addr, exp_addr());
                check("R3", "cpu_din low", cpu_din, 8'h00);
                check("R5", "ram_wdata low", ram_wdata, vid_wr_data);
            end
            check("R4", "ram_we", ram_we, exp_we());
            check("R4", "ram_oe", ram_oe, !exp_we());
            check("R9", "pix_out", pix_out, m_sh[7]);
        end
    end

    initial begin
        #3_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    int ph_left = 2;

    task automatic step_phase();
        ph_left--;
        if (ph_left <= 0) begin
            phi_hi  = ~phi_hi;
            ph_left = 2 + int'($urandom % 3);
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 5) ^ (i >> 3));
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #2;
            step_phase();
            cpu_dout = 8'($urandom);
        end
        @(posedge clk); #2;
        rst = 1'b0;
        phi_hi = 1'b0; ph_left = 3;
        @(negedge clk);
        // R10: cleared state seen at the ports right after reset
        check("R10", "pix_out after reset", pix_out, 1'b0);
        check("R10", "video addr after reset", ram_addr, 19'd0);
        running = 1'b1;
        for (int c = 0; c < 6000; c++) begin
            @(posedge clk); #2;
            step_phase();
            cpu_addr        = 16'($urandom);
            cpu_dout        = 8'($urandom);
            cpu_we          = ($urandom % 3) == 0;
            vid_blank       = ($urandom % 4) == 0;
            vid_wr_req      = ($urandom % 2) == 0;
            vid_wr_data     = 8'($urandom);
            pix_tick        = ($urandom % 2) == 0;
            vid_frame_start = ($urandom % 40) == 0;
            if ((c % 500) == 0) begin
                vid_frame_base  = 19'h7FFFF;   // drives R6 wrap
                vid_frame_start = 1'b1;
            end else if ((c % 97) == 0) begin
                vid_frame_base  = 19'($urandom);  // R7 reload target
            end
        end
        @(negedge clk);
        running  = 1'b0;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // R6, R7 and R8 are observed through the video-half ram_addr (R1 check)
    // and through pix_out (R9 check), both of which depend on the count and
    // the fetched byte.

endmodule